// File: doc/BRIEF.md
# Flash Program/Erase Completion Poller

This block runs on the host side of an asynchronous parallel flash bus. It follows a program or erase operation that has already been launched and tells the host when the operation has finished and whether it succeeded. A one-cycle start pulse latches a target address, a method select and, for program, the byte that was written. The poller then issues repeated read cycles at that address and judges the returned status byte. It does not look at any ready pin.

Two methods are offered. The toggle method watches bit 6, which flips on every read while the flash is busy. The data-polling method watches bit 7, which shows the written bit (program) or a 1 (erase) once the operation is over. Bit 5 flags a possible failure. Because the flash can finish in the same read window in which bit 5 rises, the poller makes one extra check before it reports an error. A bounded read count guards against a flash that never answers. The outcome comes back as a done pulse carrying a two-bit result code.

Top module: `flash_done_poller`

## Requirements
- R1: Every read cycle drives `bus_addr_o` with the latched target address. It holds `bus_ce_n_o` and `bus_oe_n_o` low for exactly ACC_CYC clock cycles and captures the data in the last of them. It then holds both strobes high for REC_CYC cycles before the next read or the end of the operation.
- R2: In toggle mode (`mode_i` = 0), the operation is complete when two consecutive reads return the same value on bit 6. The result is then pass (code 2'b00).
- R3: In data-polling mode (`mode_i` = 1), a read is complete when bit 7 equals bit 7 of `exp_data_i` for program (`erase_i` = 0), or equals 1 for erase (`erase_i` = 1). The result is then pass.
- R4: A read that shows the operation still busy and has bit 5 set starts a check. The check is two further reads in toggle mode and one further read in polling mode. If the check does not show completion, the result is device error (2'b01). In toggle mode the first read of a run shows nothing about busy, so its bit 5 is not acted on.
- R5: If the check reads do show completion, the result is pass.
- R6: When MAX_POLLS reads made outside a check have not shown completion and no check has started, the result is timeout (2'b10). A check that starts on the last allowed read still runs to its end.
- R7: Status bits 0, 1 and 4 (and all bits other than 7, 6 and 5) have no effect on the result or on the number of reads.
- R8: `done_o` is high for exactly one cycle per operation, and `result_o` is valid in that cycle. `done_o` rises in the cycle after the last recovery cycle of the final read, and no read starts after it.
- R9: A start pulse received while an operation is in progress is ignored: the address, the method and the read sequence stay unchanged.
- R10: While `rst_n` is low, and after reset, both strobes are high and `done_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin tracking |
| mode_i | input | 1 | 0 = toggle method, 1 = data-polling method |
| erase_i | input | 1 | 1 = erase operation, 0 = program operation |
| addr_i | input | ADDR_W | Programmed address or address inside the erased block |
| exp_data_i | input | 8 | Byte that was programmed |
| bus_addr_o | output | ADDR_W | Flash address bus |
| bus_ce_n_o | output | 1 | Flash chip enable, active low |
| bus_oe_n_o | output | 1 | Flash output enable, active low |
| bus_data_i | input | 8 | Flash data bus |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 2 | 00 pass, 01 device error, 10 timeout |

## Verification
Each read's data is judged at the end of its recovery, so `done_o` is due in the cycle after the REC_CYC-th high cycle of the final read. The bench samples one time step after each falling clock edge. It counts the cycles the strobe has been high and checks that this count equals REC_CYC+1 when `done_o` is first seen. It also checks that `done_o` has dropped on the following falling edge. A flash model counts read strobes, so the expected number of reads comes from the requirements: B+2 for toggle, B+1 for polling, E+3 or E+2 for an error, and MAX_POLLS for a timeout. This count is compared after each operation, together with the strobe widths measured on every read.

// File: rtl/flash_done_poller.sv
module flash_done_poller #(
  parameter int ADDR_W    = 20,
  parameter int ACC_CYC   = 3,
  parameter int REC_CYC   = 2,
  parameter int MAX_POLLS = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              mode_i,
  input  logic              erase_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        exp_data_i,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic              bus_ce_n_o,
  output logic              bus_oe_n_o,
  input  logic [7:0]        bus_data_i,
  output logic              done_o,
  output logic [1:0]        result_o
);
  localparam int TMAX = (ACC_CYC > REC_CYC) ? ACC_CYC : REC_CYC;
  localparam int TW   = $clog2(TMAX + 1);
  localparam int CW   = $clog2(MAX_POLLS + 1);
  localparam logic [1:0] RES_PASS = 2'b00;
  localparam logic [1:0] RES_ERR  = 2'b01;
  localparam logic [1:0] RES_TMO  = 2'b10;

  typedef enum logic [1:0] {S_IDLE, S_ACC, S_REC} st_t;

  st_t               st;
  logic [TW-1:0]     tmr;
  logic [CW-1:0]     cnt;
  logic              poll_q, erase_q, exp7_q;
  logic [ADDR_W-1:0] addr_q;
  logic              d7_q, d6_q, d5_q;
  logic              prev6, have_prev, chk_q;
  logic              done_q;
  logic [1:0]        res_q;

  assign bus_addr_o = addr_q;
  assign bus_ce_n_o = (st != S_ACC);
  assign bus_oe_n_o = (st != S_ACC);
  assign done_o     = done_q;
  assign result_o   = res_q;

  wire last_acc = (st == S_ACC) && (tmr == TW'(ACC_CYC - 1));
  wire last_rec = (st == S_REC) && (tmr == TW'(REC_CYC - 1));

  wire          pol_hit = (d7_q == (erase_q | exp7_q));
  wire          tog_hit = have_prev && (d6_q == prev6);
  wire          hit     = poll_q ? pol_hit : tog_hit;
  wire          judged  = poll_q | have_prev;
  wire [CW-1:0] cnt_nx  = cnt + CW'(1);

  logic       fin, go_chk;
  logic [1:0] fres;

  always_comb begin
    fin    = 1'b0;
    go_chk = 1'b0;
    fres   = RES_PASS;
    if (hit) begin
      fin = 1'b1;
    end else if (chk_q && judged) begin
      fin  = 1'b1;
      fres = RES_ERR;
    end else if (!chk_q && judged && d5_q) begin
      go_chk = 1'b1;
    end else if (!chk_q && cnt_nx == CW'(MAX_POLLS)) begin
      fin  = 1'b1;
      fres = RES_TMO;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      tmr       <= '0;
      cnt       <= '0;
      poll_q    <= 1'b0;
      erase_q   <= 1'b0;
      exp7_q    <= 1'b0;
      addr_q    <= '0;
      d7_q      <= 1'b0;
      d6_q      <= 1'b0;
      d5_q      <= 1'b0;
      prev6     <= 1'b0;
      have_prev <= 1'b0;
      chk_q     <= 1'b0;
      done_q    <= 1'b0;
      res_q     <= RES_PASS;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (start_i) begin
          st        <= S_ACC;
          tmr       <= '0;
          cnt       <= '0;
          poll_q    <= mode_i;
          erase_q   <= erase_i;
          exp7_q    <= exp_data_i[7];
          addr_q    <= addr_i;
          have_prev <= 1'b0;
          chk_q     <= 1'b0;
        end
        S_ACC: begin
          if (last_acc) begin
            d7_q <= bus_data_i[7];
            d6_q <= bus_data_i[6];
            d5_q <= bus_data_i[5];
            tmr  <= '0;
            st   <= S_REC;
          end else begin
            tmr <= tmr + TW'(1);
          end
        end
        S_REC: begin
          if (!last_rec) begin
            tmr <= tmr + TW'(1);
          end else if (fin) begin
            st     <= S_IDLE;
            done_q <= 1'b1;
            res_q  <= fres;
          end else begin
            st  <= S_ACC;
            tmr <= '0;
            if (!chk_q) cnt <= cnt_nx;
            if (go_chk) begin
              chk_q     <= 1'b1;
              have_prev <= 1'b0;
            end else begin
              have_prev <= 1'b1;
              prev6     <= d6_q;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [TW-1:0] low_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           low_run <= '0;
    else if (!bus_oe_n_o) low_run <= low_run + TW'(1);
    else                  low_run <= '0;
  end

  p_acc_width_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_oe_n_o) |-> low_run == TW'(ACC_CYC))
    else $error("read strobe width differs from ACC_CYC");

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o)
    else $error("done held longer than one cycle");

  p_done_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (result_o != 2'b11) && bus_ce_n_o && bus_oe_n_o)
    else $error("bad result code or strobe active at done");

  p_err_after_check_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && result_o == RES_ERR) |-> chk_q)
    else $error("device error reported without a check");

  p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE && start_i) |=> $stable(bus_addr_o))
    else $error("address changed by start while busy");
endmodule

// File: tb/tb_flash_done_poller.sv
module tb_flash_done_poller;
  localparam int AW  = 20;
  localparam int ACC = 3;
  localparam int REC = 2;
  localparam int MAXP = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0, mode = 1'b0, erase = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    expd = '0;
  logic [AW-1:0] bus_addr;
  logic          bus_ce_n, bus_oe_n, done;
  logic [7:0]    bus_data;
  logic [1:0]    result;

  always #5 clk = ~clk;

  flash_done_poller #(.ADDR_W(AW), .ACC_CYC(ACC), .REC_CYC(REC), .MAX_POLLS(MAXP)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .mode_i(mode), .erase_i(erase),
    .addr_i(addr), .exp_data_i(expd), .bus_addr_o(bus_addr), .bus_ce_n_o(bus_ce_n),
    .bus_oe_n_o(bus_oe_n), .bus_data_i(bus_data), .done_o(done), .result_o(result));

  int checks = 0, errors = 0;
  int rd_cnt = 0, mon_err = 0, low_len = 0, hi_len = 100;
  int cur_b = 0, cur_e = 255;
  logic cur_erase = 1'b0;
  logic [7:0] cur_exp = '0;
  logic [AW-1:0] cur_addr = '0;

  // flash model: B busy reads, bit 5 set on busy reads from index E on
  logic [7:0] fdata;
  int idx;
  logic fbusy;
  always_comb begin
    idx   = rd_cnt - 1;
    fbusy = idx < cur_b;
    fdata = 8'h00;
    fdata[7] = fbusy ? (cur_erase ? 1'b0 : ~cur_exp[7]) : (cur_erase ? 1'b1 : cur_exp[7]);
    fdata[6] = fbusy ? idx[0] : cur_b[0];
    fdata[5] = fbusy && (idx >= cur_e);
    fdata[4] = idx[1];   // R7 masked bits vary on every read
    fdata[1] = ~idx[0];
    fdata[0] = idx[2];
  end
  assign bus_data = bus_oe_n ? 8'h00 : fdata;

  always @(negedge bus_oe_n) begin
    rd_cnt = rd_cnt + 1;
    if (bus_addr !== cur_addr || bus_ce_n !== 1'b0) mon_err = mon_err + 1;
  end

  always @(negedge clk) begin
    if (!bus_oe_n) begin
      if (low_len == 0 && hi_len < REC) mon_err = mon_err + 1;
      low_len = low_len + 1;
      hi_len  = 0;
    end else begin
      if (low_len != 0 && low_len != ACC) mon_err = mon_err + 1;
      low_len = 0;
      hi_len  = hi_len + 1;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic launch(input bit m, input bit er, input logic [7:0] ex,
                        input int b, input int e, input logic [AW-1:0] a);
    @(negedge clk); #1;
    cur_b = b; cur_e = e; cur_erase = er; cur_exp = ex; cur_addr = a;
    rd_cnt = 0; mon_err = 0;
    mode = m; erase = er; expd = ex; addr = a; start = 1'b1;
    @(negedge clk); #1;
    start = 1'b0;
  endtask

  task automatic finish_op(input int res, input int reads, input string tag);
    int n;
    n = 0;
    while (!done && n < 2000) begin
      @(negedge clk); #1;
      n++;
    end
    check(done == 1'b1, {tag, " done seen"}, done, 1);
    check(result == 2'(res), {tag, " result"}, result, res);
    check(rd_cnt == reads, {tag, " read count"}, rd_cnt, reads);
    check(hi_len == REC + 1, {"R8 done timing ", tag}, hi_len, REC + 1);
    check(mon_err == 0, {"R1 strobe/address ", tag}, mon_err, 0);
    @(negedge clk); #1;
    check(done == 1'b0, {"R8 single pulse ", tag}, done, 0);
  endtask

  // {mode, erase, exp[7:0], busy B[7:0], err E[7:0], result[1:0], reads[7:0]}
  localparam int NV = 14;
  localparam logic [35:0] VEC [NV] = '{
    {1'b0, 1'b0, 8'h00, 8'd0,   8'd255, 2'd0, 8'd2},   // R2 immediate
    {1'b0, 1'b0, 8'h00, 8'd5,   8'd255, 2'd0, 8'd7},   // R2 after toggling
    {1'b1, 1'b0, 8'hA5, 8'd0,   8'd255, 2'd0, 8'd1},   // R3 program, R7
    {1'b1, 1'b0, 8'h3C, 8'd4,   8'd255, 2'd0, 8'd5},   // R3 program bit7=0, R7
    {1'b1, 1'b1, 8'h00, 8'd6,   8'd255, 2'd0, 8'd7},   // R3 erase
    {1'b0, 1'b0, 8'h00, 8'd255, 8'd3,   2'd1, 8'd6},   // R4 toggle error
    {1'b1, 1'b0, 8'h80, 8'd255, 8'd2,   2'd1, 8'd4},   // R4 polling error
    {1'b1, 1'b1, 8'h00, 8'd3,   8'd2,   2'd0, 8'd4},   // R5 polling late completion
    {1'b0, 1'b0, 8'h00, 8'd4,   8'd3,   2'd0, 8'd6},   // R5 toggle late completion
    {1'b0, 1'b0, 8'h00, 8'd255, 8'd255, 2'd2, 8'd16},  // R6 toggle timeout
    {1'b1, 1'b0, 8'h00, 8'd255, 8'd255, 2'd2, 8'd16},  // R6 polling timeout
    {1'b0, 1'b0, 8'h00, 8'd255, 8'd15,  2'd1, 8'd18},  // R6 check on last read
    {1'b1, 1'b1, 8'h00, 8'd255, 8'd40,  2'd2, 8'd16},  // R6 bit5 beyond limit
    {1'b0, 1'b0, 8'h00, 8'd255, 8'd0,   2'd1, 8'd4}    // R4 first toggle read ignored
  };

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(bus_ce_n == 1'b1 && bus_oe_n == 1'b1, "R10 strobes in reset", {bus_ce_n, bus_oe_n}, 3);
    check(done == 1'b0, "R10 done in reset", done, 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check(bus_oe_n == 1'b1 && done == 1'b0, "R10 idle after reset", bus_oe_n, 1);

    for (int i = 0; i < NV; i++) begin
      logic [35:0] v;
      v = VEC[i];
      launch(v[35], v[34], v[33:26], int'(v[25:18]), int'(v[17:10]), AW'(20'h01000 + i * 20'h00111));
      finish_op(int'(v[9:8]), int'(v[7:0]), $sformatf("R2-vec%0d", i));
    end

    // R9: second start while busy is ignored
    launch(1'b0, 1'b0, 8'h00, 8, 255, 20'hABCDE);
    repeat (12) @(negedge clk);
    #1;
    mode = 1'b1; erase = 1'b1; addr = 20'h12345; start = 1'b1;
    @(negedge clk); #1;
    start = 1'b0;
    finish_op(0, 10, "R9 start while busy");
    repeat (10) @(negedge clk);
    #1;
    check(rd_cnt == 10, "R9 no extra reads after done", rd_cnt, 10);
    check(bus_addr == 20'hABCDE, "R9 address unchanged", bus_addr, 20'hABCDE);

    // R10: reset in the middle of an operation
    launch(1'b0, 1'b0, 8'h00, 255, 255, 20'h00777);
    repeat (7) @(negedge clk);
    #1;
    rst_n = 1'b0;
    @(negedge clk); #1;
    check(bus_ce_n == 1'b1 && bus_oe_n == 1'b1, "R10 strobes after mid-op reset", bus_oe_n, 1);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    #1;
    check(done == 1'b0 && bus_oe_n == 1'b1, "R10 stays idle", done, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule